// File: doc/BRIEF.md
# External Status Change Interrupt Latch

This block watches six status sources for each of two serial channels and raises a status interrupt when an enabled source changes level in either direction. The sources are break/abort, transmit underrun/end-of-message, clear-to-send, sync/hunt, carrier detect and baud-counter-zero. Each channel keeps a snapshot of its sources for the status byte. The snapshot follows the inputs while the channel is idle. It is frozen from the cycle the interrupt is raised until software issues the reset command for that channel.

The block also builds the two-channel pending byte. This byte merges each channel's status pending latch with receive and transmit pending flags that arrive ready-made from elsewhere. The interrupt request combines the per-source enables, a per-channel status enable and a master enable.

Top module: `extStatusIrq`

## Requirements
- R1: After reset, both status pending latches are clear, the pending byte is 0x00 and `irq` is low.
- R2: A 0-to-1 change on a source whose enable bit is set, with the channel enable set, sets that channel's status pending latch. The latch is visible one clock after the edge on which the new level is sampled.
- R3: A 1-to-0 change on an enabled source sets the pending latch in the same way as a 0-to-1 change.
- R4: Source vector bit order, MSB first, is {break, txUnderrun, cts, syncHunt, dcd, zeroCount}, and enable bit i gates source bit i. A change on a source whose enable bit is clear leaves the pending latch clear.
- R5: With the channel enable low, no source change sets that channel's latch. `irq` is high exactly when `masterIe` is high and any of pending byte bits 5:0 is set.
- R6: The status byte is {break, txUnderrun, cts, syncHunt, dcd, txEmpty, zeroCount, rxReady} at bits 7 to 0. Bits 2 and 0 always follow their live inputs. The other bits show the sources sampled one clock earlier while the latch is clear, and stay frozen at the values captured when the latch set for as long as it stays set.
- R7: The channel reset command clears the pending latch and re-samples the live sources into the snapshot. Without the command, the latch stays set.
- R8: Further source changes while the latch is set do not produce a second interrupt. Once the reset command has cleared the latch, it stays clear until a new change occurs.
- R9: The pending byte is {0, 0, rxPendA, txPendA, statPendA, rxPendB, txPendB, statPendB} at bits 7 to 0.
- R10: A source change in the same cycle as the reset command leaves the latch set and loads the new level into the snapshot.
- R11: The two channels are independent: activity on one never sets the other's latch or changes its status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcA | input | 6 | Channel A status sources (R4 order) |
| srcB | input | 6 | Channel B status sources |
| srcEnA | input | 6 | Channel A per-source enables |
| srcEnB | input | 6 | Channel B per-source enables |
| chanIeA | input | 1 | Channel A status interrupt enable |
| chanIeB | input | 1 | Channel B status interrupt enable |
| masterIe | input | 1 | Master interrupt enable |
| resetCmdA | input | 1 | Channel A reset-status command, one-cycle pulse |
| resetCmdB | input | 1 | Channel B reset-status command, one-cycle pulse |
| txEmptyA | input | 1 | Channel A transmit buffer empty |
| rxReadyA | input | 1 | Channel A receive character ready |
| txEmptyB | input | 1 | Channel B transmit buffer empty |
| rxReadyB | input | 1 | Channel B receive character ready |
| rxPendA | input | 1 | Channel A receive interrupt pending |
| txPendA | input | 1 | Channel A transmit interrupt pending |
| rxPendB | input | 1 | Channel B receive interrupt pending |
| txPendB | input | 1 | Channel B transmit interrupt pending |
| statusA | output | 8 | Channel A status byte |
| statusB | output | 8 | Channel B status byte |
| statPendA | output | 1 | Channel A status pending latch |
| statPendB | output | 1 | Channel B status pending latch |
| pendByte | output | 8 | Combined pending byte |
| irq | output | 1 | Interrupt request |

## Verification
Re-arming by the reset command and a fresh source change can land in the same cycle. The bench first sets a channel's latch. It then raises the reset command and flips an enabled source together, at one falling clock edge. It then expects the latch to still be set and the flipped bit to show its new level in the frozen snapshot. The sweep also issues the command after a source has toggled back during the pending window. There the expected result is a clear latch and a snapshot equal to the live level.

// File: rtl/extStatusPkg.sv
package extStatusPkg;
  localparam int SRC_W  = 6;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic capture;   // load snapshot from live sources
    logic setPend;   // raise status pending
    logic clrPend;   // reset command seen
  } statStrobe_t;
endpackage

// File: rtl/extStatusData.sv
module extStatusData
  import extStatusPkg::*;
#(
  parameter int W = SRC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] src,
  input  logic [W-1:0] enMask,
  input  statStrobe_t  strobe,
  output logic [W-1:0] edgeVec,
  output logic [W-1:0] snap
);
  logic [W-1:0] srcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
      snap <= '0;
    end else begin
      srcQ <= src;
      if (strobe.capture) snap <= src;
    end
  end

  always_comb edgeVec = (src ^ srcQ) & enMask;
endmodule

// File: rtl/extStatusCtrl.sv
module extStatusCtrl
  import extStatusPkg::*;
#(
  parameter int W = SRC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] edgeVec,
  input  logic         chanIe,
  input  logic         resetCmd,
  output statStrobe_t  strobe,
  output logic         pend
);
  logic primed;

  always_comb begin
    strobe.capture = !pend || resetCmd;
    strobe.setPend = primed && (|edgeVec) && chanIe && (!pend || resetCmd);
    strobe.clrPend = resetCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      pend   <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (strobe.setPend)      pend <= 1'b1;
      else if (strobe.clrPend) pend <= 1'b0;
    end
  end

  assert_pend_needs_chanie_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend) |-> $past(chanIe));
  assert_pend_needs_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend) |-> $past(edgeVec != '0));
  assert_pend_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !resetCmd) |=> pend);
  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resetCmd && edgeVec == '0) |=> !pend);
endmodule

// File: rtl/extStatusIrq.sv
module extStatusIrq
  import extStatusPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] srcA,
  input  logic [5:0] srcB,
  input  logic [5:0] srcEnA,
  input  logic [5:0] srcEnB,
  input  logic       chanIeA,
  input  logic       chanIeB,
  input  logic       masterIe,
  input  logic       resetCmdA,
  input  logic       resetCmdB,
  input  logic       txEmptyA,
  input  logic       rxReadyA,
  input  logic       txEmptyB,
  input  logic       rxReadyB,
  input  logic       rxPendA,
  input  logic       txPendA,
  input  logic       rxPendB,
  input  logic       txPendB,
  output logic [7:0] statusA,
  output logic [7:0] statusB,
  output logic       statPendA,
  output logic       statPendB,
  output logic [7:0] pendByte,
  output logic       irq
);
  logic [SRC_W-1:0] srcArr  [NUM_CH];
  logic [SRC_W-1:0] enArr   [NUM_CH];
  logic [SRC_W-1:0] snapArr [NUM_CH];
  logic [NUM_CH-1:0] ieArr, cmdArr, pendArr, txEArr, rxRArr;
  logic [7:0]        statArr [NUM_CH];

  always_comb begin
    srcArr[0] = srcA;   srcArr[1] = srcB;
    enArr[0]  = srcEnA; enArr[1]  = srcEnB;
    ieArr     = {chanIeB, chanIeA};
    cmdArr    = {resetCmdB, resetCmdA};
    txEArr    = {txEmptyB, txEmptyA};
    rxRArr    = {rxReadyB, rxReadyA};
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    statStrobe_t      strobe;
    logic [SRC_W-1:0] edgeVec;

    extStatusData #(.W(SRC_W)) u_data (
      .clk(clk), .rstN(rstN), .src(srcArr[ch]), .enMask(enArr[ch]),
      .strobe(strobe), .edgeVec(edgeVec), .snap(snapArr[ch]));

    extStatusCtrl #(.W(SRC_W)) u_ctrl (
      .clk(clk), .rstN(rstN), .edgeVec(edgeVec), .chanIe(ieArr[ch]),
      .resetCmd(cmdArr[ch]), .strobe(strobe), .pend(pendArr[ch]));

    always_comb statArr[ch] = {snapArr[ch][5:1], txEArr[ch], snapArr[ch][0], rxRArr[ch]};

    assert_frozen_status_R6: assert property (@(posedge clk) disable iff (!rstN)
      (pendArr[ch] && !cmdArr[ch]) |=> $stable({statArr[ch][7:3], statArr[ch][1]}));
  end

  always_comb begin
    statusA   = statArr[0];
    statusB   = statArr[1];
    statPendA = pendArr[0];
    statPendB = pendArr[1];
    pendByte  = {2'b00, rxPendA, txPendA, pendArr[0], rxPendB, txPendB, pendArr[1]};
    irq       = masterIe && (|pendByte[5:0]);
  end
endmodule

// File: tb/extStatusIrq_tb.sv
module extStatusIrq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] srcA = '0, srcB = '0, srcEnA = '0, srcEnB = '0;
  logic chanIeA = 0, chanIeB = 0, masterIe = 0, resetCmdA = 0, resetCmdB = 0;
  logic txEmptyA = 0, rxReadyA = 0, txEmptyB = 0, rxReadyB = 0;
  logic rxPendA = 0, txPendA = 0, rxPendB = 0, txPendB = 0;
  logic [7:0] statusA, statusB, pendByte;
  logic statPendA, statPendB, irq;
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extStatusIrq u_dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  function automatic int posOf(int s); return (s < 5) ? 7 - s : 1; endfunction

  task automatic setSrc(int ch, logic [5:0] v);
    if (ch == 0) srcA = v; else srcB = v;
  endtask
  task automatic pulseCmd(int ch);
    if (ch == 0) resetCmdA = 1; else resetCmdB = 1;
    step();
    resetCmdA = 0; resetCmdB = 0;
  endtask
  function automatic logic pendOf(int ch); return ch == 0 ? statPendA : statPendB; endfunction
  function automatic logic [7:0] statOf(int ch); return ch == 0 ? statusA : statusB; endfunction

  initial begin
    #(CLK_PERIOD*20000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    step(); step();
    check("R1 pendByte", pendByte, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rstN = 1; step(); step();
    check("R1 pend after release", {6'b0, statPendA, statPendB}, 8'h00);
    chanIeA = 1; chanIeB = 1; masterIe = 1;

    // sweep: channel x source x enabled x direction
    for (int ch = 0; ch < 2; ch++)
      for (int s = 0; s < 6; s++)
        for (int en = 0; en < 2; en++)
          for (int dir = 0; dir < 2; dir++) begin
            logic [5:0] bit1, base, flip;
            int p;
            bit1 = 6'b1 << (5 - s);
            p = posOf(s);
            base = dir ? 6'h3F : 6'h00;
            flip = base ^ bit1;
            srcEnA = 0; srcEnB = 0;
            setSrc(ch, base); step(); step();
            pulseCmd(ch); step();
            if (ch == 0) srcEnA = en ? bit1 : ~bit1; else srcEnB = en ? bit1 : ~bit1;
            setSrc(ch, flip); step();
            check(dir ? "R3 falling edge pend" : "R2 rising edge pend",
                  {7'b0, pendOf(ch)}, {7'b0, 1'(en)});
            check("R4 disabled/enabled source", {7'b0, pendOf(ch)}, {7'b0, 1'(en)});
            check("R11 other channel quiet", {7'b0, pendOf(1 - ch)}, 8'h00);
            step();
            check("R6 status bit position", {7'b0, statOf(ch)[p]}, {7'b0, flip[5 - s]});
            check("R9 pending byte", pendByte, en ? (ch == 0 ? 8'h08 : 8'h01) : 8'h00);
            check("R5 irq", {7'b0, irq}, {7'b0, 1'(en)});
            if (en) begin
              setSrc(ch, base); step(); step();
              check("R6 frozen status", {7'b0, statOf(ch)[p]}, {7'b0, flip[5 - s]});
              check("R8 single pending", {7'b0, pendOf(ch)}, 8'h01);
              pulseCmd(ch);
              check("R7 reset clears", {7'b0, pendOf(ch)}, 8'h00);
              step();
              check("R7 resample", {7'b0, statOf(ch)[p]}, {7'b0, base[5 - s]});
              check("R8 stays clear", {7'b0, pendOf(ch)}, 8'h00);
            end
          end

    // R5: channel enable low blocks the latch; master enable gates irq
    srcEnA = 6'h3F; srcA = 0; step(); pulseCmd(0); step();
    chanIeA = 0; srcA = 6'h3F; step(); step();
    check("R5 chanIe low", {7'b0, statPendA}, 8'h00);
    chanIeA = 1; masterIe = 0; srcA = 6'h00; step();
    check("R5 pend with master off", {7'b0, statPendA}, 8'h01);
    check("R5 irq master off", {7'b0, irq}, 8'h00);
    masterIe = 1; step();
    check("R5 irq master on", {7'b0, irq}, 8'h01);

    // R10: edge in the same cycle as the reset command
    resetCmdA = 1; srcA = 6'h20; step(); resetCmdA = 0;
    check("R10 pend kept", {7'b0, statPendA}, 8'h01);
    check("R10 snapshot new", statusA & 8'hFA, 8'h80);
    pulseCmd(0); step();
    check("R10 cleared later", {7'b0, statPendA}, 8'h00);

    // R6 live bits and R9 rx/tx inputs
    txEmptyA = 1; rxReadyB = 1; step();
    check("R6 live txEmpty", statusA & 8'h05, 8'h04);
    check("R6 live rxReady B", statusB & 8'h05, 8'h01);
    rxPendA = 1; txPendB = 1; step();
    check("R9 rx/tx bits", pendByte, 8'h22);
    txPendA = 1; rxPendB = 1; rxPendA = 0; txPendB = 0; step();
    check("R9 rx/tx bits swap", pendByte, 8'h14);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule